// File: doc/BRIEF.md
# Direct-Mapped Page Translation Buffer

This block translates 32-bit virtual addresses to physical addresses for a RISC core using 8 KiB pages. There are two separate banks of 64 entries, one for instruction fetch and one for data access. Each bank is a single-way, direct-mapped array. Every entry holds a match word and a translate word. The match word carries the virtual page number and a valid flag. The translate word carries the physical page number and the access-right bits.

A lookup is purely combinational. The entry is selected by the low six bits of the virtual page number. The result is one of three states: no match, invalid or hit. On a hit the block also returns the physical address and the rights that apply to the current privilege mode.

Software fills and inspects the entries through a special-register port. The register address is split into a group number in bits 15:11 and an offset in bits 10:0. When software clears an entry's valid flag, the block raises a one-cycle flush request that carries the page named by the entry's previous match word.

Top module: `page_xlate_tlb`

## Requirements
- R1: After reset every entry of both banks is zero: register reads return 0, a lookup of virtual page 0 reports invalid, and a lookup of any other page reports no match.
- R2: Lookup status is encoded 2'b00 no match, 2'b01 invalid, 2'b10 hit. The entry index is vaddr[18:13]. If bits 31:13 of the indexed match word differ from vaddr[31:13], the status is no match, even when the index agrees.
- R3: If the page numbers agree but match-word bit 0 (valid) is clear, the status is invalid. Whenever the status is not hit, the physical address and the rights output are zero.
- R4: On a hit the physical address is the translate word's bits 31:13 joined with vaddr[12:0].
- R5: Rights are reported as {execute, write, read}. For an instruction fetch (lk_fetch=1), execute comes from translate bit 7 in supervisor mode and from bit 6 in user mode. Read and write are 0 for a fetch.
- R6: For a data access (lk_fetch=0), read and write come from translate bits 8 and 9 in supervisor mode, and from bits 6 and 7 in user mode. Execute is 0 for a data access.
- R7: Fetch lookups use only the group-2 bank, and data lookups use only the group-1 bank.
- R8: In group 1 (data) or group 2 (instruction), the match word of entry i sits at offset 512+i and the translate word at offset 640+i. Read data appears on sr_rdata the cycle after the read strobe and holds until the next read. Any other offset reads as 0.
- R9: A write of a match word with bit 0 clear raises flush_req for one cycle, the cycle after the write. flush_addr then carries the entry's previous match word with bits 12:0 cleared. A match write with bit 0 set raises no flush.
- R10: Writes to offsets 768 to 1023 (the second-way ranges) change no stored word and no lookup result, and reads of those offsets return 0.
- R11: A register write and a lookup or read of the same entry in one cycle see the old contents. The new contents are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all entries |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| lk_fetch | input | 1 | 1 = instruction fetch, 0 = data read/write |
| lk_status | output | 2 | Lookup result: 00 no match, 01 invalid, 10 hit |
| lk_paddr | output | 32 | Physical address on a hit, else 0 |
| lk_perm | output | 3 | Granted rights {execute, write, read} on a hit, else 0 |
| sr_we | input | 1 | Register write strobe |
| sr_re | input | 1 | Register read strobe |
| sr_addr | input | 16 | Register address: group in [15:11], offset in [10:0] |
| sr_wdata | input | 32 | Register write data |
| sr_rdata | output | 32 | Register read data, valid the cycle after sr_re |
| flush_req | output | 1 | One-cycle request to flush a page |
| flush_addr | output | 32 | Page address to flush (bits 12:0 zero) |

## Verification
The interesting collision is a software write to an entry landing in the same cycle as a lookup, or a read, of that same entry. The bench provokes it by presenting a translate-word write, a read strobe to the same register and a matching data lookup all in one cycle. Within that cycle, the lookup must still return the old physical address. The read data that appears on the next cycle must be the old word. After the edge, the lookup must return the new physical address. A second collision, invalidating an entry that is already valid, is judged by checking that the flush address names the previous page and not the newly written one.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int VA_W      = 32;
    localparam int PAGE_BITS = 13;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int ENTRIES   = 64;
    localparam int IDX_W     = $clog2(ENTRIES);
    localparam int GRP_W     = 5;
    localparam int OFF_W     = 11;
    localparam int ADDR_W    = GRP_W + OFF_W;

    localparam logic [GRP_W-1:0] GRP_DATA = 5'd1;
    localparam logic [GRP_W-1:0] GRP_INST = 5'd2;
    localparam int MR_BASE = 512;
    localparam int TR_BASE = 640;

    // translate-word right bits
    localparam int B_UX = 6;
    localparam int B_SX = 7;
    localparam int B_UR = 6;
    localparam int B_UW = 7;
    localparam int B_SR = 8;
    localparam int B_SW = 9;

    typedef enum logic [1:0] {
        LK_NOMATCH = 2'b00,
        LK_INVALID = 2'b01,
        LK_HIT     = 2'b10
    } lk_status_e;

    typedef struct packed {
        logic [VA_W-1:0] mr;
        logic [VA_W-1:0] tr;
    } entry_t;

    typedef struct packed {
        logic            sel_mr;
        logic            sel_tr;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;
endpackage

// File: rtl/xlt_regdec.sv
module xlt_regdec
    import xlt_pkg::*;
#(
    parameter logic [GRP_W-1:0] GROUP = GRP_DATA
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    logic [GRP_W-1:0] grp;
    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] mr_rel;
    logic [OFF_W-1:0] tr_rel;

    always_comb begin
        grp        = addr[ADDR_W-1:OFF_W];
        off        = addr[OFF_W-1:0];
        mr_rel     = off - OFF_W'(MR_BASE);
        tr_rel     = off - OFF_W'(TR_BASE);
        sel.sel_mr = (grp == GROUP) && (off >= OFF_W'(MR_BASE))
                     && (off < OFF_W'(MR_BASE + ENTRIES));
        sel.sel_tr = (grp == GROUP) && (off >= OFF_W'(TR_BASE))
                     && (off < OFF_W'(TR_BASE + ENTRIES));
        sel.idx    = sel.sel_tr ? tr_rel[IDX_W-1:0] : mr_rel[IDX_W-1:0];
    end
endmodule

// File: rtl/xlt_bank.sv
module xlt_bank
    import xlt_pkg::*;
#(
    parameter logic [GRP_W-1:0] GROUP = GRP_DATA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [VA_W-1:0]   wdata,
    output logic [VA_W-1:0]   rd_word,
    input  logic [IDX_W-1:0]  lk_idx,
    output entry_t            lk_ent,
    output logic              flush_q_o,
    output logic [VA_W-1:0]   flush_addr_o
);
    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic                 flush;
        logic [VA_W-1:0]      flush_addr;
    } bank_state_t;

    bank_state_t st_d, st_q;
    reg_sel_t    sel;

    xlt_regdec #(.GROUP(GROUP)) dec_i (.addr(addr), .sel(sel));

    always_comb begin
        st_d            = st_q;
        st_d.flush      = 1'b0;
        st_d.flush_addr = '0;
        if (we && sel.sel_mr) begin
            if (!wdata[0]) begin
                st_d.flush      = 1'b1;
                st_d.flush_addr = {st_q.ent[sel.idx].mr[VA_W-1:PAGE_BITS],
                                   {PAGE_BITS{1'b0}}};
            end
            st_d.ent[sel.idx].mr = wdata;
        end
        if (we && sel.sel_tr) begin
            st_d.ent[sel.idx].tr = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (sel.sel_mr)      rd_word = st_q.ent[sel.idx].mr;
        else if (sel.sel_tr) rd_word = st_q.ent[sel.idx].tr;
        else                 rd_word = '0;
    end

    assign lk_ent       = st_q.ent[lk_idx];
    assign flush_q_o    = st_q.flush;
    assign flush_addr_o = st_q.flush_addr;
endmodule

// File: rtl/xlt_lookup.sv
module xlt_lookup
    import xlt_pkg::*;
(
    input  entry_t          ent,
    input  logic [VA_W-1:0] vaddr,
    input  logic            super_m,
    input  logic            fetch,
    output logic [1:0]      status,
    output logic [VA_W-1:0] paddr,
    output logic [2:0]      perm
);
    logic x_ok, r_ok, w_ok;

    always_comb begin
        x_ok = super_m ? ent.tr[B_SX] : ent.tr[B_UX];
        r_ok = super_m ? ent.tr[B_SR] : ent.tr[B_UR];
        w_ok = super_m ? ent.tr[B_SW] : ent.tr[B_UW];
        status = LK_NOMATCH;
        paddr  = '0;
        perm   = '0;
        if (ent.mr[VA_W-1:PAGE_BITS] != vaddr[VA_W-1:PAGE_BITS]) begin
            status = LK_NOMATCH;
        end else if (!ent.mr[0]) begin
            status = LK_INVALID;
        end else begin
            status = LK_HIT;
            paddr  = {ent.tr[VA_W-1:PAGE_BITS], vaddr[PAGE_BITS-1:0]};
            perm   = fetch ? {x_ok, 2'b00} : {1'b0, w_ok, r_ok};
        end
    end
endmodule

// File: rtl/page_xlate_tlb.sv
module page_xlate_tlb
    import xlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_super,
    input  logic              lk_fetch,
    output logic [1:0]        lk_status,
    output logic [VA_W-1:0]   lk_paddr,
    output logic [2:0]        lk_perm,
    input  logic              sr_we,
    input  logic              sr_re,
    input  logic [ADDR_W-1:0] sr_addr,
    input  logic [VA_W-1:0]   sr_wdata,
    output logic [VA_W-1:0]   sr_rdata,
    output logic              flush_req,
    output logic [VA_W-1:0]   flush_addr
);
    localparam int NBANK = 2;
    localparam logic [GRP_W-1:0] BANK_GRP [NBANK] = '{GRP_DATA, GRP_INST};

    typedef struct packed {
        logic [VA_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [VA_W-1:0] rd_word [NBANK];
    entry_t          ent     [NBANK];
    logic            fl      [NBANK];
    logic [VA_W-1:0] fl_addr [NBANK];
    logic [IDX_W-1:0] lk_idx;

    assign lk_idx = lk_vaddr[PAGE_BITS +: IDX_W];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        xlt_bank #(.GROUP(BANK_GRP[b])) bank_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .we          (sr_we),
            .addr        (sr_addr),
            .wdata       (sr_wdata),
            .rd_word     (rd_word[b]),
            .lk_idx      (lk_idx),
            .lk_ent      (ent[b]),
            .flush_q_o   (fl[b]),
            .flush_addr_o(fl_addr[b])
        );
    end

    xlt_lookup lookup_i (
        .ent    (lk_fetch ? ent[1] : ent[0]),
        .vaddr  (lk_vaddr),
        .super_m(lk_super),
        .fetch  (lk_fetch),
        .status (lk_status),
        .paddr  (lk_paddr),
        .perm   (lk_perm)
    );

    always_comb begin
        st_d = st_q;
        if (sr_re) st_d.rdata = rd_word[0] | rd_word[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sr_rdata   = st_q.rdata;
    assign flush_req  = fl[0] | fl[1];
    assign flush_addr = fl[0] ? fl_addr[0] : fl_addr[1];
endmodule

// File: rtl/xlt_checker.sv
module xlt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] lk_vaddr,
    input logic        lk_fetch,
    input logic [1:0]  lk_status,
    input logic [31:0] lk_paddr,
    input logic [2:0]  lk_perm,
    input logic        sr_we,
    input logic        sr_re,
    input logic [31:0] sr_wdata,
    input logic [31:0] sr_rdata,
    input logic        flush_req,
    input logic [31:0] flush_addr
);
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        lk_status != 2'b11);  // R2
    AST_NOHIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        lk_status != 2'b10 |-> (lk_paddr == 32'd0 && lk_perm == 3'd0));  // R3
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_status == 2'b10 |-> lk_paddr[12:0] == lk_vaddr[12:0]);  // R4
    AST_FETCH_NO_RW: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fetch |-> lk_perm[1:0] == 2'b00);  // R5
    AST_DATA_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_fetch |-> !lk_perm[2]);  // R6
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sr_re) |-> $stable(sr_rdata));  // R8
    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> ($past(sr_we) && !$past(sr_wdata[0])));  // R9
    AST_FLUSH_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> flush_addr[12:0] == 13'd0);  // R9
endmodule

bind page_xlate_tlb xlt_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_vaddr  (lk_vaddr),
    .lk_fetch  (lk_fetch),
    .lk_status (lk_status),
    .lk_paddr  (lk_paddr),
    .lk_perm   (lk_perm),
    .sr_we     (sr_we),
    .sr_re     (sr_re),
    .sr_wdata  (sr_wdata),
    .sr_rdata  (sr_rdata),
    .flush_req (flush_req),
    .flush_addr(flush_addr)
);

// File: tb/page_xlate_tlb_tb_top.sv
module page_xlate_tlb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_super = 1'b0;
    logic        lk_fetch = 1'b0;
    logic [1:0]  lk_status;
    logic [31:0] lk_paddr;
    logic [2:0]  lk_perm;
    logic        sr_we = 1'b0;
    logic        sr_re = 1'b0;
    logic [15:0] sr_addr = '0;
    logic [31:0] sr_wdata = '0;
    logic [31:0] sr_rdata;
    logic        flush_req;
    logic [31:0] flush_addr;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    page_xlate_tlb dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_vaddr(lk_vaddr), .lk_super(lk_super), .lk_fetch(lk_fetch),
        .lk_status(lk_status), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
        .sr_we(sr_we), .sr_re(sr_re), .sr_addr(sr_addr),
        .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
        .flush_req(flush_req), .flush_addr(flush_addr)
    );

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // independent expectation: {status, perm, paddr}
    function automatic logic [36:0] model(input logic [31:0] mr, input logic [31:0] tr,
                                          input logic [31:0] va, input logic sup,
                                          input logic fet);
        logic [2:0] p;
        if (mr[31:13] != va[31:13]) return {2'b00, 3'b000, 32'd0};
        if (!mr[0])                 return {2'b01, 3'b000, 32'd0};
        if (fet) p = {(sup ? tr[7] : tr[6]), 2'b00};
        else     p = {1'b0, (sup ? tr[9] : tr[7]), (sup ? tr[8] : tr[6])};
        return {2'b10, p, tr[31:13], va[12:0]};
    endfunction

    task automatic wr(input logic [4:0] g, input int off, input logic [31:0] d);
        @(negedge clk);
        sr_we = 1'b1; sr_addr = {g, 11'(off)}; sr_wdata = d;
        @(negedge clk);
        sr_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] g, input int off, output logic [31:0] v);
        @(negedge clk);
        sr_re = 1'b1; sr_addr = {g, 11'(off)};
        @(negedge clk);
        sr_re = 1'b0;
        v = sr_rdata;
    endtask

    task automatic lk(input string req, input logic [31:0] va, input logic sup,
                      input logic fet, input logic [36:0] exp);
        lk_vaddr = va; lk_super = sup; lk_fetch = fet;
        #2;
        cmp({req, " status"}, 32'(lk_status), 32'(exp[36:35]));
        cmp({req, " perm"},   32'(lk_perm),   32'(exp[34:32]));
        cmp({req, " paddr"},  lk_paddr,       exp[31:0]);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(5'd1, 512, v);  cmp("R1 data mr", v, 0);
        rd(5'd2, 640, v);  cmp("R1 inst tr", v, 0);
        lk("R1 vpn0", 32'h0000_0123, 1'b0, 1'b0, {2'b01, 3'b0, 32'd0});
        lk("R1 vpnX", 32'h0004_0000, 1'b1, 1'b1, {2'b00, 3'b0, 32'd0});
    endtask

    task automatic t_data_hit();
        logic [31:0] mr = (32'h00A5 << 13) | 32'd1;
        logic [31:0] tr = 32'h1234_6000 | 32'h40 | 32'h200;
        logic [31:0] va = (32'h00A5 << 13) | 32'h0ABC;
        wr(5'd1, 512 + 37, mr);
        wr(5'd1, 640 + 37, tr);
        lk("R6 user", va, 1'b0, 1'b0, model(mr, tr, va, 1'b0, 1'b0));
        lk("R6 super", va, 1'b1, 1'b0, model(mr, tr, va, 1'b1, 1'b0));
        lk("R4 paddr", va, 1'b0, 1'b0, {2'b10, 3'b001, 32'h1234_6ABC});
        lk("R2 alias", (32'h00E5 << 13) | 32'h4, 1'b0, 1'b0, {2'b00, 3'b0, 32'd0});
    endtask

    task automatic t_fetch();
        logic [31:0] mr = (32'h3 << 13) | 32'd1;
        logic [31:0] tr = 32'h0055_A000 | 32'h80;
        logic [31:0] va = (32'h3 << 13) | 32'h1F0;
        wr(5'd2, 512 + 3, mr);
        wr(5'd2, 640 + 3, tr);
        lk("R5 super", va, 1'b1, 1'b1, {2'b10, 3'b100, 32'h0055_A1F0});
        lk("R5 user", va, 1'b0, 1'b1, {2'b10, 3'b000, 32'h0055_A1F0});
        lk("R7 data side", va, 1'b1, 1'b0, {2'b00, 3'b0, 32'd0});
    endtask

    task automatic t_invalid();
        wr(5'd1, 512 + 7, 32'h47 << 13);
        cmp("R9 flush on clear", 32'(flush_req), 1);
        cmp("R9 flush old page", flush_addr, 0);
        lk("R3 invalid", (32'h47 << 13) | 32'h10, 1'b1, 1'b0, {2'b01, 3'b0, 32'd0});
    endtask

    task automatic t_flush();
        wr(5'd1, 512 + 37, 32'h0000_0000);
        cmp("R9 flush pulse", 32'(flush_req), 1);
        cmp("R9 flush addr", flush_addr, 32'h0014_A000);
        @(negedge clk);
        cmp("R9 one cycle", 32'(flush_req), 0);
        wr(5'd1, 512 + 37, (32'h00A5 << 13) | 32'd1);
        cmp("R9 no flush on valid", 32'(flush_req), 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        rd(5'd1, 512 + 37, v); cmp("R8 mr readback", v, (32'h00A5 << 13) | 32'd1);
        rd(5'd1, 640 + 37, v); cmp("R8 tr readback", v, 32'h1234_6240);
        rd(5'd2, 640 + 3, v);  cmp("R8 inst tr", v, 32'h0055_A080);
        rd(5'd1, 576, v);      cmp("R8 hole", v, 0);
        @(negedge clk);
        cmp("R8 hold", sr_rdata, 0);
    endtask

    task automatic t_way2();
        logic [31:0] v;
        wr(5'd1, 768 + 37, 32'hFFFF_FFFE);
        cmp("R10 no flush", 32'(flush_req), 0);
        wr(5'd1, 896 + 37, 32'hDEAD_BEEF);
        rd(5'd1, 512 + 37, v); cmp("R10 mr kept", v, (32'h00A5 << 13) | 32'd1);
        rd(5'd1, 640 + 37, v); cmp("R10 tr kept", v, 32'h1234_6240);
        rd(5'd1, 768 + 37, v); cmp("R10 read zero", v, 0);
        lk("R10 lookup kept", (32'h00A5 << 13) | 32'h0ABC, 1'b0, 1'b0,
           {2'b10, 3'b001, 32'h1234_6ABC});
    endtask

    task automatic t_same_cycle();
        logic [31:0] tra = 32'h0AAA_0000 | 32'h100;
        logic [31:0] trb = 32'h0BBB_E000 | 32'h100;
        logic [31:0] va  = (32'h9 << 13) | 32'h10;
        wr(5'd1, 512 + 9, (32'h9 << 13) | 32'd1);
        wr(5'd1, 640 + 9, tra);
        @(negedge clk);
        sr_we = 1'b1; sr_re = 1'b1; sr_addr = {5'd1, 11'(640 + 9)}; sr_wdata = trb;
        lk("R11 old in write cycle", va, 1'b1, 1'b0, {2'b10, 3'b001, 32'h0AAA_0010});
        @(negedge clk);
        sr_we = 1'b0; sr_re = 1'b0;
        cmp("R11 read old", sr_rdata, tra);
        lk("R11 new next cycle", va, 1'b1, 1'b0, {2'b10, 3'b001, 32'h0BBB_E010});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_data_hit();
        t_fetch();
        t_invalid();
        t_flush();
        t_regmap();
        t_way2();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule